// File: doc/BRIEF.md
# Select-Code Arithmetic/Logic Unit with Registered Flags

This block is an 8-bit arithmetic/logic unit that follows the classic 4-bit select, mode bit and carry-in convention. A 4-bit function code and a mode bit choose one of sixteen arithmetic or sixteen logic functions. In arithmetic mode an active-high carry input adds one to the function. Operand A comes from either the shared bus or the accumulator, and operand B comes from its own input.

A store-result strobe captures the function output into a result register. An output enable places that register on the bus. A separate store-flags strobe captures four condition flags from the function output of the same cycle: equal, carry/borrow, negative and zero. A microsequencer can therefore set up compares and branch on the stored flags without disturbing the stored result. Flags and result are independent, and each can be captured alone or together with the other.

Top module: `alu181_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the result register and all four flags are cleared to 0. After reset, `bus_out` reads 0 when enabled.
- R2: With `logic_mode`=0, the output F is computed as follows, plus one when `carry_in`=1 (all results are modulo 256):

  | `func_sel` | F | `func_sel` | F |
  |---|---|---|---|
  | 0000 | A | 1000 | A+(A&B) |
  | 0001 | A\|B | 1001 | A+B |
  | 0010 | A\|~B | 1010 | (A\|~B)+(A&B) |
  | 0011 | all-ones | 1011 | (A&B)−1 |
  | 0100 | A+(A&~B) | 1100 | A+A |
  | 0101 | (A\|B)+(A&~B) | 1101 | (A\|B)+A |
  | 0110 | A−B−1 | 1110 | (A\|~B)+A |
  | 0111 | (A&~B)−1 | 1111 | A−1 |

  So 0000 with carry gives A+1, and 0110 with carry gives A−B.
- R3: With `logic_mode`=1, the output F is set by `func_sel`, and `carry_in` has no effect:

  | `func_sel` | F | `func_sel` | F |
  |---|---|---|---|
  | 0000 | ~A | 1000 | ~A\|B |
  | 0001 | ~(A\|B) | 1001 | ~(A^B) |
  | 0010 | ~A&B | 1010 | B |
  | 0011 | 0 | 1011 | A&B |
  | 0100 | ~(A&B) | 1100 | all-ones |
  | 0101 | ~B | 1101 | A\|~B |
  | 0110 | A^B | 1110 | A\|B |
  | 0111 | A&~B | 1111 | A |
- R4: Operand A is `bus_in` when `a_from_bus`=1 and `acc_in` otherwise.
- R5: The result register takes F at a clock edge where `store_result`=1. It holds its value at every other edge.
- R6: `bus_out` equals the result register while `out_en`=1 and is 0 otherwise. `bus_oe` follows `out_en`.
- R7: The four flags take their new values at an edge where `store_flags`=1 and hold at every other edge. The new values are derived from F of that cycle, whether or not `store_result` is set.
- R8: In arithmetic mode, `flag_carry` is the carry out of bit 7 of the sum, with the same active-high sense as `carry_in`. For example, A−B with carry gives 1 when A≥B unsigned. In logic mode `flag_carry` is stored as 0.
- R9: `flag_equal` is set when F is all ones. Under code 0110, arithmetic mode and no carry, this means A equals B.
- R10: `flag_negative` is bit 7 of F, and `flag_zero` is set when F equals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Bus value, usable as operand A |
| acc_in | input | 8 | Accumulator value, usable as operand A |
| opb_in | input | 8 | Operand B |
| a_from_bus | input | 1 | 1 selects `bus_in` as operand A |
| func_sel | input | 4 | Function select code |
| logic_mode | input | 1 | 1 = logic functions, 0 = arithmetic |
| carry_in | input | 1 | Active-high carry, adds one in arithmetic mode |
| store_result | input | 1 | Load the result register |
| store_flags | input | 1 | Load the flag register |
| out_en | input | 1 | Drive the result onto the bus |
| bus_out | output | 8 | Result while enabled, else 0 |
| bus_oe | output | 1 | Bus drive indication |
| flag_equal | output | 1 | Stored equal flag |
| flag_carry | output | 1 | Stored carry/borrow flag |
| flag_negative | output | 1 | Stored negative flag |
| flag_zero | output | 1 | Stored zero flag |

## Verification
The bench sweeps all thirty-two function codes with and without carry. It targets the places where the carry polarity matters:
- A−1 from 0 must not carry.
- A−B with carry must carry exactly when A≥B.
- A+A of 0x80 must wrap to zero with a carry.

A design with inverted carry sense would give A−B−1 where A−B is expected and report the borrow backwards. A design that lets carry reach logic mode would corrupt codes such as all-ones or NOT A. Separate store strobes are also exercised: a design that stores flags on a result-only strobe, or gates the bus late, would show stale or leaked values at the bus and flag pins.

// File: rtl/alu181_pkg.sv
package alu181_pkg;
  localparam int ALU_W = 8;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic eq;
    logic cy;
    logic neg;
    logic zero;
  } alu_flags_t;

  localparam alu_flags_t FLAGS_CLEAR = '{eq: 1'b0, cy: 1'b0, neg: 1'b0, zero: 1'b0};
endpackage

// File: rtl/alu181_opmux.sv
module alu181_opmux #(
  parameter int W = 8
) (
  input  logic         pick_bus,
  input  logic [W-1:0] from_bus,
  input  logic [W-1:0] from_acc,
  output logic [W-1:0] opa
);
  always_comb begin
    opa = pick_bus ? from_bus : from_acc;
  end
endmodule

// File: rtl/alu181_core.sv
module alu181_core #(
  parameter int W = 8,
  parameter int S = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [S-1:0] sel,
  input  logic         mode,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         cout
);
  localparam int SW = W + 1;

  logic [W-1:0] x_term, y_term, lg;
  logic [SW-1:0] sum;

  // Arithmetic: F = X + Y + cin, where the select bits gate the terms.
  always_comb begin
    x_term = a | (b & {W{sel[0]}}) | (~b & {W{sel[1]}});
    y_term = (a & ~b & {W{sel[2]}}) | (a & b & {W{sel[3]}});
    sum    = {1'b0, x_term} + {1'b0, y_term} + {{(SW-1){1'b0}}, cin};
  end

  always_comb begin
    case (sel)
      4'b0000: lg = ~a;
      4'b0001: lg = ~(a | b);
      4'b0010: lg = ~a & b;
      4'b0011: lg = '0;
      4'b0100: lg = ~(a & b);
      4'b0101: lg = ~b;
      4'b0110: lg = a ^ b;
      4'b0111: lg = a & ~b;
      4'b1000: lg = ~a | b;
      4'b1001: lg = ~(a ^ b);
      4'b1010: lg = b;
      4'b1011: lg = a & b;
      4'b1100: lg = '1;
      4'b1101: lg = a | ~b;
      4'b1110: lg = a | b;
      default: lg = a;
    endcase
  end

  always_comb begin
    f    = mode ? lg : sum[W-1:0];
    cout = mode ? 1'b0 : sum[W];
  end
endmodule

// File: rtl/alu181_flagreg.sv
module alu181_flagreg
  import alu181_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         mode,
  input  logic [W-1:0] f,
  input  logic         cout,
  output alu_flags_t   flags_q
);
  alu_flags_t next_flags;

  always_comb begin
    next_flags.eq   = &f;
    next_flags.cy   = cout;
    next_flags.neg  = f[W-1];
    next_flags.zero = ~|f;
  end

  always_ff @(posedge clk) begin
    if (rst)       flags_q <= FLAGS_CLEAR;
    else if (load) flags_q <= next_flags;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(flags_q)); // R7
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
    flags_q.zero |-> !flags_q.neg); // R10
  AST_EQ_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    flags_q.eq |-> !flags_q.zero); // R9
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (load && mode) |=> !flags_q.cy); // R8
endmodule

// File: rtl/alu181_unit.sv
module alu181_unit
  import alu181_pkg::*;
#(
  parameter int W = ALU_W,
  parameter int S = SEL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opb_in,
  input  logic         a_from_bus,
  input  logic [S-1:0] func_sel,
  input  logic         logic_mode,
  input  logic         carry_in,
  input  logic         store_result,
  input  logic         store_flags,
  input  logic         out_en,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         flag_equal,
  output logic         flag_carry,
  output logic         flag_negative,
  output logic         flag_zero
);
  logic [W-1:0] opa, core_f, result_q;
  logic         core_cout;
  alu_flags_t   flags_q;

  alu181_opmux #(.W(W)) u_opmux (
    .pick_bus (a_from_bus),
    .from_bus (bus_in),
    .from_acc (acc_in),
    .opa      (opa)
  );

  alu181_core #(.W(W), .S(S)) u_core (
    .a    (opa),
    .b    (opb_in),
    .sel  (func_sel),
    .mode (logic_mode),
    .cin  (carry_in),
    .f    (core_f),
    .cout (core_cout)
  );

  alu181_flagreg #(.W(W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .load    (store_flags),
    .mode    (logic_mode),
    .f       (core_f),
    .cout    (core_cout),
    .flags_q (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst)               result_q <= '0;
    else if (store_result) result_q <= core_f;
  end

  always_comb begin
    bus_out       = out_en ? result_q : '0;
    bus_oe        = out_en;
    flag_equal    = flags_q.eq;
    flag_carry    = flags_q.cy;
    flag_negative = flags_q.neg;
    flag_zero     = flags_q.zero;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!store_result) |=> $stable(result_q)); // R5
  AST_ARITH_PASS: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && func_sel == '0 && !carry_in) |-> core_f == opa); // R2
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (logic_mode && func_sel == 4'b0011) |-> core_f == '0); // R3
endmodule

// File: tb/alu181_unit_test.sv
`timescale 1ns/1ps
module alu181_unit_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_in, acc_in, opb_in;
  logic       a_from_bus, logic_mode, carry_in, store_result, store_flags, out_en;
  logic [3:0] func_sel;
  logic [7:0] bus_out;
  logic       bus_oe, flag_equal, flag_carry, flag_negative, flag_zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_res = 0;
  bit m_eq = 0, m_cy = 0, m_neg = 0, m_zero = 0;

  always #2 clk = ~clk;

  alu181_unit uut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .acc_in(acc_in), .opb_in(opb_in),
    .a_from_bus(a_from_bus), .func_sel(func_sel), .logic_mode(logic_mode),
    .carry_in(carry_in), .store_result(store_result), .store_flags(store_flags),
    .out_en(out_en), .bus_out(bus_out), .bus_oe(bus_oe), .flag_equal(flag_equal),
    .flag_carry(flag_carry), .flag_negative(flag_negative), .flag_zero(flag_zero)
  );

  // Function table from the requirements, as integers; returns 9 bits {carry, F}.
  function automatic int ref_fn(int a, int b, int s, bit m, bit c);
    int nb, t;
    nb = (~b) & 255;
    if (m) begin
      case (s)
        0: t = ~a;        1: t = ~(a | b);  2: t = (~a) & b;  3: t = 0;
        4: t = ~(a & b);  5: t = ~b;        6: t = a ^ b;     7: t = a & nb;
        8: t = (~a) | b;  9: t = ~(a ^ b);  10: t = b;        11: t = a & b;
        12: t = 255;      13: t = a | nb;   14: t = a | b;    default: t = a;
      endcase
      return t & 255;
    end
    case (s)
      0: t = a;                    1: t = a | b;
      2: t = a | nb;               3: t = 255;
      4: t = a + (a & nb);         5: t = (a | b) + (a & nb);
      6: t = a + nb;               7: t = (a & nb) + 255;
      8: t = a + (a & b);          9: t = a + b;
      10: t = (a | nb) + (a & b);  11: t = (a & b) + 255;
      12: t = a + a;               13: t = (a | b) + a;
      14: t = (a | nb) + a;        default: t = a + 255;
    endcase
    return (t + int'(c)) & 511;
  endfunction

  always @(posedge clk) begin
    int a, r, f;
    if (rst) begin
      m_res = 0; m_eq = 0; m_cy = 0; m_neg = 0; m_zero = 0;
    end else begin
      a = a_from_bus ? int'(bus_in) : int'(acc_in);
      r = ref_fn(a, int'(opb_in), int'(func_sel), logic_mode, carry_in);
      f = r & 255;
      if (store_result) m_res = f;
      if (store_flags) begin
        m_eq = (f == 255); m_cy = r[8]; m_neg = f[7]; m_zero = (f == 0);
      end
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp({req, "/R6"}, "bus_out", int'(bus_out), out_en ? m_res : 0);
    cmp("R6", "bus_oe", int'(bus_oe), int'(out_en));
    cmp({req, "/R9"}, "flag_equal", int'(flag_equal), int'(m_eq));
    cmp({req, "/R8"}, "flag_carry", int'(flag_carry), int'(m_cy));
    cmp({req, "/R10"}, "flag_negative", int'(flag_negative), int'(m_neg));
    cmp({req, "/R10"}, "flag_zero", int'(flag_zero), int'(m_zero));
  endtask

  // Check outputs of the previous cycle, then apply a new operation.
  task automatic op(string req, int a, int b, int s, bit m, bit c,
                    bit sr = 1, bit sf = 1, bit oe = 1, bit fb = 0);
    @(negedge clk);
    check_all(req);
    acc_in = fb ? 8'h5A : 8'(a);
    bus_in = fb ? 8'(a) : 8'hA5;
    a_from_bus = fb; opb_in = 8'(b); func_sel = 4'(s); logic_mode = m;
    carry_in = c; store_result = sr; store_flags = sf; out_en = oe;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_in = 0; acc_in = 0; opb_in = 0; a_from_bus = 0; func_sel = 0;
    logic_mode = 0; carry_in = 0; store_result = 1; store_flags = 1; out_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst = 0;
    // R2 directed arithmetic corners
    op("R2", 8'h41, 0, 0, 0, 1);          // A+1
    op("R2", 8'h41, 0, 0, 0, 0);          // A
    op("R2", 8'h00, 0, 15, 0, 0);         // 0-1 -> FF, no carry (R8)
    op("R2", 8'h05, 0, 15, 0, 0);         // 5-1 -> 4, carry
    op("R2", 8'hF0, 8'h20, 9, 0, 0);      // A+B wrap
    op("R2", 8'hF0, 8'h0F, 9, 0, 1);      // A+B+1 -> 0
    op("R9", 8'h37, 8'h37, 6, 0, 0);      // equal compare -> FF
    op("R8", 8'h37, 8'h37, 6, 0, 1);      // A-B = 0, carry
    op("R8", 8'h03, 8'h05, 6, 0, 1);      // A<B: no carry, negative
    op("R8", 8'h09, 8'h05, 6, 0, 1);      // A>B: carry
    op("R2", 8'h80, 0, 12, 0, 0);         // A+A -> 0, carry, zero
    op("R2", 8'h40, 0, 12, 0, 1);         // A+A+1
    // R3 logic with carry both ways (R8: carry flag stays 0)
    for (int s = 0; s < 16; s++) op("R3", 8'hC6, 8'hA3, s, 1, s[0]);
    for (int s = 0; s < 16; s++) op("R3", 8'h3C, 8'h5A, s, 1, ~s[0]);
    // R2 full arithmetic sweep
    for (int s = 0; s < 16; s++) op("R2", 8'h9D, 8'h47, s, 0, 0);
    for (int s = 0; s < 16; s++) op("R2", 8'h62, 8'hB9, s, 0, 1);
    // R4 operand A from bus
    op("R4", 8'h11, 8'h01, 0, 0, 1, 1, 1, 1, 1);
    op("R4", 8'hFE, 8'h01, 9, 0, 1, 1, 1, 1, 1);
    // R5 result held, flags move (R7)
    op("R5", 8'h01, 8'h01, 9, 0, 0, 0, 1, 1);
    op("R5", 8'h00, 8'h00, 3, 1, 0, 0, 1, 1);
    // R7 flags held, result moves
    op("R7", 8'h80, 8'h00, 0, 0, 0, 1, 0, 1);
    op("R7", 8'hFF, 8'h00, 15, 0, 0, 1, 0, 1);
    // R6 bus gated off while result stored
    op("R6", 8'h77, 0, 0, 0, 0, 1, 1, 0);
    op("R6", 8'h78, 0, 0, 0, 0, 0, 0, 1);
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      int v;
      v = (i * 40503 + 12345) ^ (i << 7);
      op("R2/R3", v & 255, (v >> 8) & 255, (v >> 3) & 15, v[17], v[11],
         v[12] | v[13], v[14] | v[15], v[16] | v[9], v[10]);
    end
    // R1 reset mid-run
    @(negedge clk); check_all("R2");
    rst = 1; store_result = 0; store_flags = 0;
    @(negedge clk); check_all("R1");
    rst = 0; out_en = 1;
    @(negedge clk); check_all("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule